// File: doc/BRIEF.md
# Double-to-Int32 Wrapping Conversion Unit

This unit decodes and executes one floating-point instruction. The instruction converts a 64-bit IEEE-754 double to a signed 32-bit integer, rounding toward zero. For finite inputs, an integer part that does not fit in 32 bits is not clamped to a limit. Instead the unit keeps its low 32 bits, which is the integer part modulo 2^32. NaN and both infinities produce zero. The 32-bit value is sign-extended to the integer register width, which a parameter sets to 32 or 64.

Each cycle, the surrounding pipeline presents an instruction word, the double operand read from the floating-point register file, two feature-enable bits and a valid strobe. One cycle later the unit returns four things: a result-valid strobe, an illegal-instruction indication, the integer result and the accrued exception flags. Register-file access, pipeline control and the flag CSR are handled by the caller.

Top module: `fcvt_mod_unit`

## Requirements
- R1: An instruction word matches only when bits [31:25]=1100001, [24:20]=01000, [14:12]=001 and [6:0]=1010011. The source index in bits [19:15] and the destination index in bits [11:7] take any value and do not affect the match.
- R2: If the rounding field in bits [14:12] holds any value other than 001 (toward zero), the word does not match and is reported as illegal.
- R3: A matching word is legal only when both `en_dbl` and `en_xfp` are 1. A word that is not legal raises `out_illegal`, and its `out_result` and `out_flags` are zero.
- R4: A NaN, +infinity or -infinity operand gives result 0 and sets only the invalid flag.
- R5: A finite operand whose truncated integer lies outside [-2^31, 2^31-1] gives the low 32 bits of that integer in two's complement, sign-extended. It sets only the invalid flag. When every significant bit weighs 2^32 or more, those low bits are zero.
- R6: An in-range finite operand gives its integer part truncated toward zero. The inexact flag is set exactly when nonzero fraction bits were discarded.
- R7: Zero of either sign gives 0 and no flags. A subnormal gives 0 and sets only the inexact flag.
- R8: `out_result` is the 32-bit value sign-extended to XLEN bits.
- R9: `out_valid` is 1 in the cycle after `in_valid` was 1 and 0 otherwise. Result, flags and illegal indication belong to that input. Reset clears `out_valid`.
- R10: `out_flags` bit 4 is invalid and bit 0 is inexact. Bits 3..1 are always 0, and invalid and inexact are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operand are valid this cycle |
| instr | input | 32 | Instruction word |
| src_d | input | 64 | Double-precision operand |
| en_dbl | input | 1 | Double-precision feature enabled |
| en_xfp | input | 1 | Additional floating-point instructions enabled |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_illegal | output | 1 | Instruction illegal |
| out_result | output | XLEN | Sign-extended integer result |
| out_flags | output | 5 | Exception flags: bit 4 invalid, bit 0 inexact |

## Verification
The bench targets the range boundaries. -2^31 is in range, while +2^31 and -(2^31+1) wrap. A design that compared magnitudes without the sign would flag -2^31 as invalid or fail to flag +2^31. 2^32+5 and -2^40-3 check that the wrapped low bits are kept and negated correctly, not saturated. 2^84 checks the case where every bit falls above the result window; a shifter that wrapped its shift amount would return garbage there. ±0.5, subnormals and zeros separate "inexact only" from "no flags". NaN and the infinities must give zero, not a limit value. Words with a wrong rounding field or a missing enable must come back illegal with a zero result.

// File: rtl/fcvtm_pkg.sv
package fcvtm_pkg;
   localparam int FLAG_W = 5;
   localparam int FLT_DW = 64;
   localparam int FLT_EW = 11;
   localparam int FLT_MW = 52;
   localparam int INT_W  = 32;

   // bit 4 invalid, bit 0 inexact
   typedef struct packed {
      logic nv;
      logic dz;
      logic of;
      logic uf;
      logic nx;
   } fflags_t;

   // instruction pattern: funct7 / rs2 / rm / opcode fixed, register indices free
   localparam logic [31:0] INSN_MASK  = 32'hFFF0_707F;
   localparam logic [31:0] INSN_MATCH = 32'hC280_1053;
endpackage

// File: rtl/fcvtm_decode.sv
module fcvtm_decode
   import fcvtm_pkg::*;
#(
   parameter logic [31:0] MASK  = INSN_MASK,
   parameter logic [31:0] MATCH = INSN_MATCH
) (
   input  logic [31:0] instr,
   input  logic        en_dbl,
   input  logic        en_xfp,
   output logic        hit,
   output logic        legal
);
   always_comb begin
      hit   = ((instr & MASK) == MATCH);
      legal = hit && en_dbl && en_xfp;
   end
endmodule

// File: rtl/fcvtm_core.sv
module fcvtm_core
   import fcvtm_pkg::*;
#(
   parameter int DW = FLT_DW,
   parameter int EW = FLT_EW,
   parameter int MW = FLT_MW,
   parameter int IW = INT_W
) (
   input  logic [DW-1:0] src,
   output logic [IW-1:0] res,
   output fflags_t       flags
);
   localparam int BIAS = (1 << (EW-1)) - 1;
   localparam int WW   = MW + IW;            // fraction bits + integer window
   localparam int SW   = $clog2(WW);
   localparam int UEW  = EW + 2;

   initial begin
      if (DW != 1 + EW + MW) $fatal(1, "fcvtm_core: DW must be 1+EW+MW");
      if (IW < 2 || IW > MW + 1) $fatal(1, "fcvtm_core: IW out of supported range");
   end

   logic                  sgn;
   logic [EW-1:0]         ex;
   logic [MW-1:0]         fr;
   logic signed [UEW-1:0] ue;
   logic                  e_all1, e_zero, e_neg, e_big;
   logic [SW-1:0]         shamt;
   logic [WW-1:0]         wide;
   logic [IW-1:0]         low;
   logic                  frac_nz, in_rng;

   always_comb begin
      sgn    = src[DW-1];
      ex     = src[DW-2:MW];
      fr     = src[MW-1:0];
      e_all1 = &ex;
      e_zero = (ex == '0);
      ue     = $signed({2'b00, ex}) - $signed(UEW'(BIAS));
      e_neg  = (ue < 0);
      e_big  = (ue >= $signed(UEW'(WW)));
      shamt  = (e_neg || e_big) ? '0 : ue[SW-1:0];
      wide   = {{(WW-MW-1){1'b0}}, 1'b1, fr} << shamt;
      low     = wide[WW-1:MW];
      frac_nz = |wide[MW-1:0];
      if (ue < $signed(UEW'(IW-1)))
         in_rng = 1'b1;
      else if (ue == $signed(UEW'(IW-1)))
         in_rng = sgn && (wide[WW-2:MW] == '0);  // exactly -2^(IW-1)
      else
         in_rng = 1'b0;

      res   = '0;
      flags = '0;
      if (e_all1) begin
         flags.nv = 1'b1;
      end else if (e_zero) begin
         flags.nx = |fr;
      end else if (e_neg) begin
         flags.nx = 1'b1;
      end else if (e_big) begin
         flags.nv = 1'b1;
      end else begin
         res      = sgn ? (~low + 1'b1) : low;
         flags.nv = !in_rng;
         flags.nx = in_rng && frac_nz;
      end
   end
endmodule

// File: rtl/fcvtm_sext.sv
module fcvtm_sext #(
   parameter int IW   = 32,
   parameter int XLEN = 64
) (
   input  logic [IW-1:0]   din,
   output logic [XLEN-1:0] dout
);
   generate
      if (XLEN == IW) begin : g_same
         assign dout = din;
      end else if (XLEN > IW) begin : g_ext
         assign dout = {{(XLEN-IW){din[IW-1]}}, din};
      end else begin : g_bad
         initial $fatal(1, "fcvtm_sext: XLEN narrower than IW");
         assign dout = din[XLEN-1:0];
      end
   endgenerate
endmodule

// File: rtl/fcvt_mod_unit.sv
module fcvt_mod_unit
   import fcvtm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     instr,
   input  logic [63:0]     src_d,
   input  logic            en_dbl,
   input  logic            en_xfp,
   output logic            out_valid,
   output logic            out_illegal,
   output logic [XLEN-1:0] out_result,
   output logic [4:0]      out_flags
);
   initial begin
      if (!(XLEN == 32 || XLEN == 64)) $fatal(1, "fcvt_mod_unit: XLEN must be 32 or 64");
   end

   logic            dec_hit, dec_legal;
   logic [INT_W-1:0] cv_res;
   fflags_t         cv_flags;
   logic [XLEN-1:0] cv_ext;

   fcvtm_decode u_dec (
      .instr (instr),
      .en_dbl(en_dbl),
      .en_xfp(en_xfp),
      .hit   (dec_hit),
      .legal (dec_legal)
   );

   fcvtm_core #(.DW(FLT_DW), .EW(FLT_EW), .MW(FLT_MW), .IW(INT_W)) u_core (
      .src  (src_d),
      .res  (cv_res),
      .flags(cv_flags)
   );

   fcvtm_sext #(.IW(INT_W), .XLEN(XLEN)) u_sext (
      .din (cv_res),
      .dout(cv_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
         out_flags   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_illegal <= !dec_legal;
            out_result  <= dec_legal ? cv_ext : '0;
            out_flags   <= dec_legal ? cv_flags : '0;
         end
      end
   end

   // R9: one-cycle strobe
   p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10: only invalid/inexact, never both
   p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_flags[3:1] == 3'b000) && !(out_flags[4] && out_flags[0]));
   // R2: wrong rounding field is illegal
   p_rm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[14:12] != 3'b001) |=> out_illegal);
   // R3: illegal gives zero result and flags
   p_illz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_result == '0) && (out_flags == 5'b0));
   // R4: NaN / infinity
   p_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_legal && (&src_d[62:52])) |=> (out_result == '0) && (out_flags == 5'b10000));
   // R8: sign extension
   p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_result[XLEN-1:31] == '0) || (&out_result[XLEN-1:31]));
endmodule

// File: tb/sim_fcvt_mod_unit.sv
module sim_fcvt_mod_unit;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [63:0]     src_d = '0;
   logic            en_dbl = 1'b0;
   logic            en_xfp = 1'b0;
   logic            out_valid, out_illegal;
   logic [XLEN-1:0] out_result;
   logic [4:0]      out_flags;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #4 clk = ~clk;   // 125 MHz

   fcvt_mod_unit #(.XLEN(XLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .src_d(src_d),
      .en_dbl(en_dbl), .en_xfp(en_xfp), .out_valid(out_valid), .out_illegal(out_illegal),
      .out_result(out_result), .out_flags(out_flags)
   );

   function automatic logic [31:0] mk_insn(input logic [4:0] rs, input logic [4:0] rd, input logic [2:0] rm);
      return {7'b1100001, 5'b01000, rs, rm, rd, 7'b1010011};
   endfunction

   // behavioural model built from the requirements
   function automatic void model(input logic [63:0] d, output logic [31:0] r, output logic [4:0] fl);
      int e, u, k;
      longint unsigned mag;
      logic [52:0] m;
      bit fracbit, big, inr, s;
      s = d[63];
      e = int'(d[62:52]);
      r = '0; fl = '0;
      if (e == 2047) begin fl = 5'b10000; return; end
      if (e == 0) begin fl = (d[51:0] != 0) ? 5'b00001 : 5'b0; return; end
      u = e - 1023;
      m = {1'b1, d[51:0]};
      mag = 0; fracbit = 0; big = 0;
      for (int i = 0; i < 53; i++) begin
         if (m[i]) begin
            k = u - 52 + i;
            if (k < 0) fracbit = 1;
            else begin
               if (k < 32) r = r | (32'd1 << k);
               if (k >= 40) big = 1; else mag = mag + (64'd1 << k);
            end
         end
      end
      inr = !big && (s ? (mag <= 64'h8000_0000) : (mag <= 64'h7FFF_FFFF));
      if (s) r = -r;
      fl = inr ? (fracbit ? 5'b00001 : 5'b0) : 5'b10000;
   endfunction

   // drive at negedge, check the registered response at the following negedge
   task automatic step(input bit v, input logic [31:0] ins, input logic [63:0] d,
                       input bit ed, input bit ex, input string tag);
      logic [31:0]     r32;
      logic [4:0]      efl;
      logic [XLEN-1:0] eres;
      bit legal;
      in_valid = v; instr = ins; src_d = d; en_dbl = ed; en_xfp = ex;
      legal = (ins[6:0] == 7'b1010011) && (ins[14:12] == 3'b001) &&
              (ins[24:20] == 5'b01000) && (ins[31:25] == 7'b1100001) && ed && ex;
      model(d, r32, efl);
      eres = {{(XLEN-32){r32[31]}}, r32};
      if (!legal) begin eres = '0; efl = '0; end
      @(negedge clk);
      n_tests++;
      if (out_valid !== v) begin
         n_fail++;
         $display("FAIL %s (R9): out_valid=%0b expected %0b", tag, out_valid, v);
      end else if (v && (out_illegal !== !legal || out_result !== eres || out_flags !== efl)) begin
         n_fail++;
         $display("FAIL %s: ill/res/flg=%0b/%h/%b expected %0b/%h/%b", tag,
                  out_illegal, out_result, out_flags, !legal, eres, efl);
      end
   endtask

   task automatic cv(input logic [63:0] d, input string tag);
      step(1, mk_insn(5'd3, 5'd10, 3'b001), d, 1, 1, tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || out_result !== '0 || out_flags !== '0) begin
         n_fail++;
         $display("FAIL reset (R9): valid=%0b res=%h flg=%b expected 0/0/0", out_valid, out_result, out_flags);
      end
      rst_n = 1'b1;
      @(negedge clk);

      cv(64'h3FE0_0000_0000_0000, "R6 +0.5");
      cv(64'hBFE0_0000_0000_0000, "R6 -0.5");
      cv(64'hC00C_0000_0000_0000, "R6 -3.5");
      cv(64'h41DF_FFFF_FFC0_0000, "R6 +(2^31-1)");
      cv(64'hC1DF_FFFF_FFC0_0000, "R6 -(2^31-1)");
      cv(64'hC1E0_0000_0000_0000, "R6 -2^31 in range");
      cv(64'hC1E0_0000_0010_0000, "R6 -2^31-0.5 inexact");
      cv(64'h41E0_0000_0000_0000, "R5 +2^31 wraps");
      cv(64'hC1E0_0000_0020_0000, "R5 -(2^31+1) wraps");
      cv(64'h41F0_0000_0050_0000, "R5 2^32+5");
      cv(64'hC270_0000_0000_3000, "R5 -2^40-3");
      cv(64'h4530_0000_0000_0000, "R5 2^84");
      cv(64'h4520_0000_0000_0001, "R5 2^83 lsb");
      cv(64'h7FF8_0000_0000_0000, "R4 NaN");
      cv(64'h7FF0_0000_0000_0001, "R4 sNaN");
      cv(64'h7FF0_0000_0000_0000, "R4 +inf");
      cv(64'hFFF0_0000_0000_0000, "R4 -inf");
      cv(64'h0000_0000_0000_0001, "R7 +subnormal");
      cv(64'h800F_FFFF_FFFF_FFFF, "R7 -subnormal");
      cv(64'h0000_0000_0000_0000, "R7 +0");
      cv(64'h8000_0000_0000_0000, "R7 -0");
      cv(64'hC05E_C000_0000_0000, "R8 -123 sign extension");
      step(1, mk_insn(5'd3, 5'd10, 3'b000), 64'h4000_0000_0000_0000, 1, 1, "R2 rm=000");
      step(1, mk_insn(5'd3, 5'd10, 3'b111), 64'h4000_0000_0000_0000, 1, 1, "R2 rm=111");
      step(1, mk_insn(5'd3, 5'd10, 3'b101), 64'h7FF8_0000_0000_0000, 1, 1, "R2 rm=101 NaN");
      step(1, mk_insn(5'd3, 5'd10, 3'b001), 64'h4000_0000_0000_0000, 0, 1, "R3 no dbl");
      step(1, mk_insn(5'd3, 5'd10, 3'b001), 64'h4000_0000_0000_0000, 1, 0, "R3 no xfp");
      step(1, mk_insn(5'd3, 5'd10, 3'b001) ^ 32'h0010_0000, 64'h4000_0000_0000_0000, 1, 1, "R1 rs2 field");
      step(1, mk_insn(5'd3, 5'd10, 3'b001) ^ 32'h0000_0004, 64'h4000_0000_0000_0000, 1, 1, "R1 opcode");
      step(1, mk_insn(5'd3, 5'd10, 3'b001) ^ 32'h0200_0000, 64'h4000_0000_0000_0000, 1, 1, "R1 funct7");
      step(1, mk_insn(5'd31, 5'd0, 3'b001), 64'h4000_0000_0000_0000, 1, 1, "R1 indices free");
      step(0, mk_insn(5'd3, 5'd10, 3'b001), 64'h4000_0000_0000_0000, 1, 1, "R9 idle");
      step(0, '0, '0, 0, 0, "R9 idle 2");
      cv(64'h4008_0000_0000_0000, "R9 back-to-back a");
      cv(64'hC008_0000_0000_0000, "R9 back-to-back b");

      for (int i = 0; i < 600; i++) begin
         logic [63:0] d;
         d = {$urandom, $urandom};
         if (i % 4 != 0) d[62:52] = 11'(1023 - 8 + ($urandom % 100));
         step(($urandom % 5) != 0, mk_insn(5'($urandom), 5'($urandom),
              (($urandom % 8) == 0) ? 3'($urandom) : 3'b001), d,
              ($urandom % 10) != 0, ($urandom % 10) != 0, "R10 random");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule